// File: doc/BRIEF.md
# Multi-Cycle Register-Machine Execution Core

This block is a compact 32-bit execution core. It runs a 16-opcode instruction set over sixteen register indices. Each instruction is a single 32-bit word, read from a word-addressed memory through a request/ready port. An instruction may be followed by one immediate word. Each of the three register fields carries its own indirect bit. When that bit is set, the register supplies a memory address, so either source, or the destination, can be a memory word. The instruction pointer is an ordinary register-file entry. A program can therefore read it, or overwrite it with a plain move.

Character traffic uses two byte streams, each with a valid/ready handshake. The core runs from address 0 after reset until it meets a halt. It then parks, with its halted output asserted, until the next reset. Every step waits on its handshake, so memory and character latency are free to vary.

Top module: `regm_core`

## Requirements
- R1: While reset is asserted, every register is cleared. The first action after reset is an instruction read at address 0, with `halted_o` low.
- R2: The instruction word has these fields: opcode in bits 31:28, immediate flag in bit 27, indirect bits 26/25/24 for the destination, first source and second source, and register fields in 11:8 (destination), 7:4 (first source) and 3:0 (second source). The pointer at index 10 advances by one per instruction word, and by two when the immediate flag is set. Reading index 10 during execution returns the already-advanced value.
- R3: Index 0 and index 15 read as zero, and writes to them are lost.
- R4: The opcodes are 1 move (destination gets the second source), 2 add, 3 subtract, 4 multiply (low 32 bits), 8 nand and 9 xor. Each computes from the first and second source.
- R5: Opcode 6 is a logical right shift and opcode 7 a left shift. Both use only bits 4:0 of the second source as the amount.
- R6: Opcode 5 is unsigned division. A zero divisor yields 0xFFFFFFFF.
- R7: A set source indirect bit replaces the register value with the memory word at that address. When the immediate flag is set, the immediate word is the second source and bit 24 is ignored.
- R8: When bit 26 is set, the result is stored to memory at the address held in the destination register, and no register changes.
- R9: Only subtract updates the flags. Index 14 reads as SF in bit 0 (the sign of the result) and ZF in bit 1 (set when the result is zero). All other bits read zero. A write to index 14 keeps only bits 1:0, and a subtract's flag update wins over it.
- R10: Opcode 10 jumps to the second source. Opcode 11 jumps only when ZF is 1, and opcode 12 only when ZF is 0. Otherwise execution falls through.
- R11: Opcode 13 waits for an input byte and writes it, zero-extended, to the destination location (register or, with bit 26 set, memory).
- R12: Opcode 14 offers the low byte of the second source on the output stream. Valid and data are held until ready is seen.
- R13: A memory request holds its address, write enable and write data until ready. At most one of memory request, input ready and output valid is active at a time.
- R14: Opcode 0 stops the core after its fetch, whatever the other bits are. After that, `halted_o` stays high and no further memory or character handshake is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| cin_valid_i | input | 1 | Input byte available |
| cin_data_i | input | 8 | Input byte |
| cin_ready_o | output | 1 | Core accepts an input byte |
| cout_valid_o | output | 1 | Output byte offered |
| cout_data_o | output | 8 | Output byte |
| cout_ready_i | input | 1 | Sink takes the output byte |
| halted_o | output | 1 | Core has stopped |

## Verification
Two events can land on the same clock edge. The first is a subtract's flag update. The second is its result commit: a register write that may name the flags register itself, or a memory store whose address is read one state later. The bench provokes this in two ways. It writes the flags register from move and add, then reads it back after subtract and non-subtract results. It also chains indirect sources and an indirect destination, all while memory ready is withheld at random. A behavioural interpreter predicts every memory, character and halt event in order. Each completed handshake, checked clock by clock, must match the head of that prediction in address and data.

// File: rtl/regm_pkg.sv
package regm_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int BYTE_W = 8;

  localparam logic [RIDX_W-1:0] REG_IP    = RIDX_W'(10);
  localparam logic [RIDX_W-1:0] REG_FLAGS = RIDX_W'(14);

  typedef enum logic [3:0] {
    OP_HALT, OP_MOVE, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SHR, OP_SHL,
    OP_NAND, OP_XOR, OP_BR, OP_BRZ, OP_BRNZ, OP_CIN, OP_COUT, OP_RSVD
  } op_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_IMM, ST_OPB, ST_OPC, ST_EXEC, ST_DIV, ST_CIN, ST_COUT,
    ST_WB, ST_HALT
  } state_e;

  typedef struct packed {
    op_e               op;
    logic              imm;
    logic              ind_a;
    logic              ind_b;
    logic              ind_c;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rc;
  } dec_t;

  function automatic dec_t decode(logic [XLEN-1:0] w);
    dec_t d;
    d.op    = op_e'(w[31:28]);
    d.imm   = w[27];
    d.ind_a = w[26];
    d.ind_b = w[25];
    d.ind_c = w[24];
    d.ra    = w[11:8];
    d.rb    = w[7:4];
    d.rc    = w[3:0];
    return d;
  endfunction
endpackage

// File: rtl/regm_regfile.sv
module regm_regfile
  import regm_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] rc_i,
  output logic [W-1:0]  ra_o,
  output logic [W-1:0]  rb_o,
  output logic [W-1:0]  rc_o,
  output logic [W-1:0]  ip_o,
  output logic          zf_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          ip_we_i,
  input  logic [W-1:0]  ip_d_i,
  input  logic          fl_we_i,
  input  logic          sf_i,
  input  logic          zf_i
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(i);
    if (i == 0 || i == N-1) begin : g_const
      assign regs[i] = '0;
    end else if (IDX == REG_FLAGS) begin : g_flags
      logic sf_q, zf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sf_q <= 1'b0;
          zf_q <= 1'b0;
        end else if (fl_we_i) begin
          sf_q <= sf_i;
          zf_q <= zf_i;
        end else if (we_i && waddr_i == IDX) begin
          sf_q <= wdata_i[0];
          zf_q <= wdata_i[1];
        end
      end
      assign regs[i] = {{(W-2){1'b0}}, zf_q, sf_q};
    end else if (IDX == REG_IP) begin : g_ip
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      q <= '0;
        else if (we_i && waddr_i == IDX)  q <= wdata_i;
        else if (ip_we_i)                 q <= ip_d_i;
      end
      assign regs[i] = q;
    end else begin : g_gp
      logic [W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      q <= '0;
        else if (we_i && waddr_i == IDX)  q <= wdata_i;
      end
      assign regs[i] = q;
    end
  end

  assign ra_o = regs[ra_i];
  assign rb_o = regs[rb_i];
  assign rc_o = regs[rc_i];
  assign ip_o = regs[REG_IP];
  assign zf_o = regs[REG_FLAGS][1];
endmodule

// File: rtl/regm_alu.sv
module regm_alu
  import regm_pkg::*;
#(
  parameter int W = XLEN,
  localparam int SHW = $clog2(W)
) (
  input  op_e          op_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] res_o
);
  logic [SHW-1:0] amt;
  logic [W-1:0]   prod;

  assign amt  = c_i[SHW-1:0];
  assign prod = b_i * c_i;

  always_comb begin
    unique case (op_i)
      OP_MOVE: res_o = c_i;
      OP_ADD:  res_o = b_i + c_i;
      OP_SUB:  res_o = b_i - c_i;
      OP_MUL:  res_o = prod;
      OP_SHR:  res_o = b_i >> amt;
      OP_SHL:  res_o = b_i << amt;
      OP_NAND: res_o = ~(b_i & c_i);
      OP_XOR:  res_o = b_i ^ c_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/regm_div.sv
module regm_div #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [W:0]    trial, diff;
  logic          fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        if (divisor_i == '0) begin
          quo_q  <= '1;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(W);
          rem_q  <= '0;
          quo_q  <= dividend_i;
          dvs_q  <= divisor_i;
        end
      end else if (busy_q) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/regm_core.sv
module regm_core
  import regm_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         mem_ready_i,
  input  logic         cin_valid_i,
  input  logic [7:0]   cin_data_i,
  output logic         cin_ready_o,
  output logic         cout_valid_o,
  output logic [7:0]   cout_data_o,
  input  logic         cout_ready_i,
  output logic         halted_o
);
  state_e       st_q, st_d;
  dec_t         ir_q;
  logic [W-1:0] opb_q, opc_q, res_q, opb_d, opc_d;
  logic         ld_ir, ld_opb, ld_opc, ld_res;

  logic [W-1:0] rf_a, rf_b, rf_c, ip;
  logic         zf, rf_we, ip_we, fl_we;
  logic [W-1:0] ip_d;
  logic         commit;
  logic [W-1:0] commit_val, alu_res, div_q;
  logic         div_start, div_done;
  logic         uses_b, uses_c, rd_b_mem, rd_c_mem;

  assign uses_b   = ir_q.op inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SHR,
                                    OP_SHL, OP_NAND, OP_XOR};
  assign uses_c   = uses_b || ir_q.op inside {OP_MOVE, OP_BR, OP_BRZ,
                                              OP_BRNZ, OP_COUT};
  assign rd_b_mem = uses_b && ir_q.ind_b;
  assign rd_c_mem = uses_c && !ir_q.imm && ir_q.ind_c;

  regm_regfile #(.W(W), .N(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_i(ir_q.ra), .rb_i(ir_q.rb), .rc_i(ir_q.rc),
    .ra_o(rf_a), .rb_o(rf_b), .rc_o(rf_c), .ip_o(ip), .zf_o(zf),
    .we_i(rf_we), .waddr_i(ir_q.ra), .wdata_i(commit_val),
    .ip_we_i(ip_we), .ip_d_i(ip_d),
    .fl_we_i(fl_we), .sf_i(commit_val[W-1]), .zf_i(commit_val == '0)
  );

  regm_alu #(.W(W)) u_alu (
    .op_i(ir_q.op), .b_i(opb_q), .c_i(opc_q), .res_o(alu_res)
  );

  regm_div #(.W(W)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .dividend_i(opb_q),
    .divisor_i(opc_q), .done_o(div_done), .quot_o(div_q)
  );

  always_comb begin
    st_d         = st_q;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = '0;
    mem_wdata_o  = res_q;
    cin_ready_o  = 1'b0;
    cout_valid_o = 1'b0;
    ld_ir = 1'b0; ld_opb = 1'b0; ld_opc = 1'b0; ld_res = 1'b0;
    opb_d = rf_b; opc_d = rf_c;
    ip_we = 1'b0; ip_d = ip + 1'b1;
    rf_we = 1'b0; fl_we = 1'b0;
    commit = 1'b0; commit_val = alu_res;
    div_start = 1'b0;
    unique case (st_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ip;
        if (mem_ready_i) begin
          ld_ir = 1'b1;
          ip_we = 1'b1;
          if (op_e'(mem_rdata_i[31:28]) == OP_HALT) st_d = ST_HALT;
          else if (mem_rdata_i[27])                 st_d = ST_IMM;
          else                                      st_d = ST_OPB;
        end
      end
      ST_IMM: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ip;
        opc_d      = mem_rdata_i;
        if (mem_ready_i) begin
          ld_opc = 1'b1;
          ip_we  = 1'b1;
          st_d   = ST_OPB;
        end
      end
      ST_OPB: begin
        if (rd_b_mem) begin
          mem_req_o  = 1'b1;
          mem_addr_o = rf_b;
          opb_d      = mem_rdata_i;
          if (mem_ready_i) begin
            ld_opb = 1'b1;
            st_d   = ST_OPC;
          end
        end else begin
          ld_opb = 1'b1;
          st_d   = ST_OPC;
        end
      end
      ST_OPC: begin
        if (ir_q.imm) begin
          st_d = ST_EXEC;
        end else if (rd_c_mem) begin
          mem_req_o  = 1'b1;
          mem_addr_o = rf_c;
          opc_d      = mem_rdata_i;
          if (mem_ready_i) begin
            ld_opc = 1'b1;
            st_d   = ST_EXEC;
          end
        end else begin
          ld_opc = 1'b1;
          st_d   = ST_EXEC;
        end
      end
      ST_EXEC: begin
        ip_d = opc_q;
        case (ir_q.op)
          OP_DIV: begin
            div_start = 1'b1;
            st_d      = ST_DIV;
          end
          OP_CIN:  st_d = ST_CIN;
          OP_COUT: st_d = ST_COUT;
          OP_BR: begin
            ip_we = 1'b1;
            st_d  = ST_FETCH;
          end
          OP_BRZ: begin
            ip_we = zf;
            st_d  = ST_FETCH;
          end
          OP_BRNZ: begin
            ip_we = !zf;
            st_d  = ST_FETCH;
          end
          OP_HALT, OP_RSVD: st_d = ST_FETCH;
          default: commit = 1'b1;
        endcase
      end
      ST_DIV: begin
        commit_val = div_q;
        commit     = div_done;
      end
      ST_CIN: begin
        cin_ready_o = 1'b1;
        commit_val  = {{(W-BYTE_W){1'b0}}, cin_data_i};
        commit      = cin_valid_i;
      end
      ST_COUT: begin
        cout_valid_o = 1'b1;
        if (cout_ready_i) st_d = ST_FETCH;
      end
      ST_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = rf_a;
        if (mem_ready_i) st_d = ST_FETCH;
      end
      default: st_d = ST_HALT;
    endcase
    // flags and result land on the same edge; flag port has priority in the file
    if (commit) begin
      fl_we = (ir_q.op == OP_SUB);
      if (ir_q.ind_a) begin
        ld_res = 1'b1;
        st_d   = ST_WB;
      end else begin
        rf_we = 1'b1;
        st_d  = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      ir_q  <= '0;
      opb_q <= '0;
      opc_q <= '0;
      res_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_ir)  ir_q  <= decode(mem_rdata_i);
      if (ld_opb) opb_q <= opb_d;
      if (ld_opc) opc_q <= opc_d;
      if (ld_res) res_q <= commit_val;
    end
  end

  assign cout_data_o = opc_q[BYTE_W-1:0];
  assign halted_o    = (st_q == ST_HALT);
endmodule

// File: rtl/regm_core_chk.sv
module regm_core_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mem_req_o,
  input logic         mem_we_o,
  input logic [W-1:0] mem_addr_o,
  input logic [W-1:0] mem_wdata_o,
  input logic         mem_ready_i,
  input logic         cin_ready_o,
  input logic         cout_valid_o,
  input logic [7:0]   cout_data_o,
  input logic         cout_ready_i,
  input logic         halted_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assert_boot_fetch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> mem_req_o && !mem_we_o && mem_addr_o == '0 && !halted_o);

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_one_port_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, cin_ready_o, cout_valid_o}));

  assert_cout_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_valid_o && !cout_ready_i |=> cout_valid_o && $stable(cout_data_o));

  assert_halt_quiet_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !mem_req_o && !cin_ready_o && !cout_valid_o);
endmodule

bind regm_core regm_core_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_ready_i(mem_ready_i), .cin_ready_o(cin_ready_o),
  .cout_valid_o(cout_valid_o), .cout_data_o(cout_data_o),
  .cout_ready_i(cout_ready_i), .halted_o(halted_o)
);

// File: tb/regm_core_bench.sv
module regm_core_bench;
  localparam int K_RD = 0, K_WR = 1, K_CIN = 2, K_COUT = 3, K_HALT = 4;
  localparam int PROG_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic        cin_valid_i = 1'b0, cin_ready_o;
  logic [7:0]  cin_data_i = '0, cout_data_o;
  logic        cout_valid_o, cout_ready_i = 1'b0, halted_o;

  always #10 clk_i = ~clk_i;

  regm_core u_regm_core (.*);

  int vectors = 0, miscompares = 0;
  logic [31:0] mem [256];
  logic [31:0] rm  [256];
  logic [7:0]  in_bytes [$];
  int          exp_kind [$];
  logic [31:0] exp_addr [$], exp_data [$];
  logic [31:0] m_r [16];
  logic        m_sf, m_zf;
  int          pc;

  // ---------------- program building ----------------
  function automatic logic [31:0] enc(int op, bit im, bit ia, bit ib, bit ic,
                                      int a, int b, int c);
    return {op[3:0], im, ia, ib, ic, 12'h000, a[3:0], b[3:0], c[3:0]};
  endfunction
  task automatic emit(logic [31:0] w); mem[pc[7:0]] = w; pc++; endtask
  task automatic op3(int op, int a, int b, int c); emit(enc(op,0,0,0,0,a,b,c)); endtask
  task automatic opi(int op, int a, int b, logic [31:0] v);
    emit(enc(op,1,0,0,0,a,b,0)); emit(v);
  endtask
  task automatic dump(int r);
    emit(enc(1,0,1,0,0,9,0,r));
    opi(2, 9, 9, 1);
  endtask
  task automatic clear_prog();
    foreach (mem[i]) mem[i] = '0;
    in_bytes.delete();
    pc = 0;
  endtask

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] rd(int x);
    if (x == 0 || x == 15) return '0;
    if (x == 14) return {30'b0, m_zf, m_sf};
    return m_r[x];
  endfunction
  task automatic wr(int x, logic [31:0] v);
    if (x == 14) begin m_sf = v[0]; m_zf = v[1]; end
    else if (x != 0 && x != 15) m_r[x] = v;
  endtask
  task automatic push(int k, logic [31:0] a, logic [31:0] d);
    exp_kind.push_back(k); exp_addr.push_back(a); exp_data.push_back(d);
  endtask

  task automatic run_ref();
    logic [31:0] w, bv, cv, res, adr;
    int op, a, in_i;
    bit ub, uc;
    foreach (m_r[i]) m_r[i] = '0;
    m_sf = 0; m_zf = 0; in_i = 0;
    for (int steps = 0; steps < 2000; steps++) begin
      w = rm[m_r[10][7:0]];
      push(K_RD, m_r[10], 0);
      m_r[10]++;
      op = int'(w[31:28]); a = int'(w[11:8]);
      if (op == 0) begin push(K_HALT, 0, 0); return; end
      bv = '0; cv = '0; res = '0;
      if (w[27]) begin push(K_RD, m_r[10], 0); cv = rm[m_r[10][7:0]]; m_r[10]++; end
      ub = (op >= 2 && op <= 9);
      uc = ub || op == 1 || op == 10 || op == 11 || op == 12 || op == 14;
      if (ub) begin
        bv = rd(int'(w[7:4]));
        if (w[25]) begin push(K_RD, bv, 0); bv = rm[bv[7:0]]; end
      end
      if (uc && !w[27]) begin
        cv = rd(int'(w[3:0]));
        if (w[24]) begin push(K_RD, cv, 0); cv = rm[cv[7:0]]; end
      end
      case (op)
        1: res = cv;
        2: res = bv + cv;
        3: res = bv - cv;
        4: res = bv * cv;
        5: res = (cv == 0) ? 32'hFFFF_FFFF : bv / cv;
        6: res = bv >> cv[4:0];
        7: res = bv << cv[4:0];
        8: res = ~(bv & cv);
        9: res = bv ^ cv;
        10: m_r[10] = cv;
        11: if (m_zf) m_r[10] = cv;
        12: if (!m_zf) m_r[10] = cv;
        13: begin push(K_CIN, 0, 0); res = {24'b0, in_bytes[in_i]}; in_i++; end
        14: push(K_COUT, 0, {24'b0, cv[7:0]});
        default: ;
      endcase
      if ((op >= 1 && op <= 9) || op == 13) begin
        if (w[26]) begin
          if (op == 3) begin m_sf = res[31]; m_zf = (res == 0); end
          adr = rd(a);
          push(K_WR, adr, res);
          rm[adr[7:0]] = res;
        end else begin
          wr(a, res);
          if (op == 3) begin m_sf = res[31]; m_zf = (res == 0); end
        end
      end
    end
  endtask

  // ---------------- comparison ----------------
  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  task automatic take(int k, logic [31:0] a, logic [31:0] d, string tag);
    int ek; logic [31:0] ea, ed;
    vectors++;
    if (exp_kind.size() == 0) begin
      miscompares++;
      $display("FAIL %s R13: unexpected event kind %0d actual %h expected none", tag, k, a);
      return;
    end
    ek = exp_kind.pop_front(); ea = exp_addr.pop_front(); ed = exp_data.pop_front();
    if (ek != k || ((k == K_RD || k == K_WR) && a !== ea) ||
        ((k == K_WR || k == K_COUT) && d !== ed)) begin
      miscompares++;
      $display("FAIL %s R13: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
               tag, k, a, d, ek, ea, ed);
    end
  endtask

  task automatic run_prog(string tag);
    int cyc, in_idx;
    bit done;
    foreach (mem[i]) rm[i] = mem[i];
    exp_kind.delete(); exp_addr.delete(); exp_data.delete();
    run_ref();
    in_idx = 0; done = 0; cyc = 0;
    @(negedge clk_i);
    rst_ni = 1'b0; mem_ready_i = 0; cin_valid_i = 0; cout_ready_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(mem_req_o === 1'b1 && mem_addr_o === 32'h0 && halted_o === 1'b0 && mem_we_o === 1'b0,
          {tag, " R1 boot fetch"}, mem_addr_o, 32'h0);
    while (!done && cyc < PROG_LIMIT) begin
      mem_ready_i = 0; cin_valid_i = 0; cout_ready_i = 0;
      if (halted_o) begin
        take(K_HALT, 0, 0, tag);
        for (int q = 0; q < 16; q++) begin
          @(negedge clk_i);
          check(halted_o && !mem_req_o && !cin_ready_o && !cout_valid_o,
                {tag, " R14 quiet after halt"},
                {28'b0, halted_o, mem_req_o, cin_ready_o, cout_valid_o}, 32'h8);
        end
        done = 1;
      end else begin
        if (mem_req_o && $urandom_range(3) != 0) begin
          mem_ready_i = 1;
          if (mem_we_o) begin
            take(K_WR, mem_addr_o, mem_wdata_o, tag);
            mem[mem_addr_o[7:0]] = mem_wdata_o;
          end else begin
            take(K_RD, mem_addr_o, 0, tag);
            mem_rdata_i = mem[mem_addr_o[7:0]];
          end
        end
        if (cin_ready_o && $urandom_range(2) != 0) begin
          cin_valid_i = 1;
          cin_data_i  = in_bytes[in_idx];
          in_idx++;
          take(K_CIN, 0, 0, tag);
        end
        if (cout_valid_o && $urandom_range(2) != 0) begin
          cout_ready_i = 1;
          take(K_COUT, 0, {24'b0, cout_data_o}, tag);
        end
        @(negedge clk_i);
        cyc++;
      end
    end
    if (!done) begin
      miscompares++;
      $display("FAIL %s R14: no halt actual running expected halted", tag);
    end
    check(exp_kind.size() == 0, {tag, " R14 all predicted events seen"},
          exp_kind.size(), 0);
  endtask

  // ---------------- programs ----------------
  initial begin
    int p;
    // R1 R2 R3 R4: reset values, ip visibility, zero register, basic ops
    clear_prog();
    emit(enc(14,0,0,0,0,0,0,5));          // out r5, reset value
    opi(1, 9, 0, 32'h80);
    opi(1, 1, 0, 7); opi(1, 2, 0, 32'hFFFF_FFFB);
    op3(2, 3, 1, 2); dump(3);
    op3(3, 4, 1, 2); dump(4);
    op3(4, 5, 1, 2); dump(5);
    op3(8, 6, 1, 2); dump(6);
    op3(9, 7, 1, 2); dump(7);
    op3(2, 0, 1, 2); dump(0);
    op3(1, 15, 0, 1); dump(15);
    op3(1, 3, 0, 10); dump(3);            // ip after increment
    opi(4, 8, 1, 32'h2000_0000); dump(8);
    emit(0);
    run_prog("P1 R1 R2 R3 R4");

    // R5 R6: shifts and division
    clear_prog();
    opi(1, 9, 0, 32'h80);
    opi(1, 1, 0, 32'h8000_0000); opi(1, 2, 0, 33);
    op3(6, 3, 1, 2); dump(3);
    opi(1, 5, 0, 3); opi(7, 4, 5, 36); dump(4);
    opi(6, 4, 1, 31); dump(4);
    opi(1, 7, 0, 100); opi(5, 6, 7, 7); dump(6);
    op3(5, 8, 7, 0); dump(8);
    opi(5, 1, 1, 1); dump(1);
    opi(1, 2, 0, 32'hFFFF_FFFF); opi(5, 3, 2, 32'h0001_0000); dump(3);
    op3(5, 4, 5, 7); dump(4);
    emit(0);
    run_prog("P2 R5 R6");

    // R7 R8: indirect sources and destination
    clear_prog();
    mem[8'h90] = 1000; mem[8'h91] = 234;
    opi(1, 9, 0, 32'h80);
    opi(1, 1, 0, 32'h90); opi(1, 2, 0, 32'h91);
    emit(enc(2,0,0,1,1,3,1,2)); dump(3);
    emit(enc(2,1,0,1,1,4,1,0)); emit(5); dump(4);
    emit(enc(3,0,1,1,0,2,2,1));
    emit(enc(1,0,0,0,1,5,0,2)); dump(5);
    emit(enc(1,0,0,0,1,6,0,0)); dump(6);
    emit(enc(14,0,0,0,1,0,0,1));
    emit(enc(2,1,1,0,0,1,1,0)); emit(7);
    emit(enc(1,0,0,0,1,7,0,1)); dump(7);
    emit(0);
    run_prog("P3 R7 R8");

    // R9 R10: flags and branches
    clear_prog();
    opi(1, 9, 0, 32'h80);
    opi(1, 1, 0, 5); opi(3, 2, 1, 5); dump(14);
    p = pc; opi(11, 0, 0, p + 4); opi(14, 0, 0, 32'h58);
    opi(3, 2, 1, 7); dump(14);
    p = pc; opi(11, 0, 0, p + 4); opi(14, 0, 0, 32'h4E);
    p = pc; opi(12, 0, 0, p + 4); opi(14, 0, 0, 32'h59);
    opi(2, 3, 0, 0); dump(14);
    opi(1, 14, 0, 32'hFF); dump(14);
    p = pc; opi(12, 0, 0, p + 4); opi(14, 0, 0, 32'h4D);
    opi(3, 14, 1, 5); dump(14);
    p = pc; opi(1, 4, 0, p + 5); op3(10, 0, 0, 4); opi(14, 0, 0, 32'h5A);
    opi(14, 0, 0, 32'h4B);
    emit(0);
    run_prog("P4 R9 R10");

    // R11 R12: character streams
    clear_prog();
    in_bytes.push_back(8'hA5); in_bytes.push_back(8'hFE); in_bytes.push_back(8'h00);
    opi(1, 9, 0, 32'h80);
    op3(13, 1, 0, 0); dump(1);
    emit(enc(13,0,1,0,0,9,0,0));
    emit(enc(1,0,0,0,1,2,0,9));
    op3(14, 0, 0, 2);
    opi(14, 0, 0, 32'h1234_5641);
    op3(14, 0, 0, 1);
    op3(13, 0, 0, 0);
    emit(0);
    run_prog("P5 R11 R12");

    // R14: halt with other bits set stops before the immediate word
    clear_prog();
    emit(enc(0,1,1,1,1,3,4,5));
    opi(14, 0, 0, 32'h55);
    run_prog("P6 R14");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog R14: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule